// File: doc/BRIEF.md
# UART Interrupt Arbiter and Identification

This block gathers every interrupt cause of a 16550-compatible serial controller into one interrupt request line and one identification byte for software to read. The receive path, line status logic, modem status logic and FIFO storage stay outside the block. They present their current state as levels: error bits, data-ready, timeout-pending, receive FIFO fill count and trigger level, the FIFO-enable bit and the modem delta bits. The block picks the most urgent enabled cause using a fixed five-level ranking and encodes it into the identification byte.

The block holds the four-bit interrupt enable register. It also holds the "transmit holding empty" pending flag as a two-state machine (`THRE_IDLE`, `THRE_PEND`). Bus strobes move the flag: reading the identification byte, writing the enable register, writing the transmit holding register, and resetting the transmit FIFO. The transmit path moves it too, by pulsing when its holding stage has drained. The machine has five transitions: `FIFO_RESET` (to `THRE_PEND`), `TX_WRITE` (to `THRE_IDLE`), `TX_DRAINED` (to `THRE_PEND`), `ENABLE_RESAMPLE` (to either state) and `ID_READ_ACK` (to `THRE_IDLE`). When several of these occur in the same cycle they are ranked in that order.

The identification byte is built combinationally from registered state, so a read sees the cause active in that cycle. Flag updates land on the next clock.

Top module: `uart_irq_arbiter`

## Requirements
- R1: Line status has the highest rank. When enable bit 2 is set and any of the four error inputs (overrun, parity, framing, break) is 1, the identification bits 3:0 read 0x6.
- R2: Character timeout is second. When enable bit 0 is set and timeout-pending is 1, bits 3:0 read 0xC, even if received data is also waiting.
- R3: Received data is third. When enable bit 0 is set and data-ready is 1, bits 3:0 read 0x4, provided the FIFOs are disabled or the FIFO count is at or above the trigger level. A count below the trigger level with FIFOs enabled gives no receive-data cause.
- R4: Transmit-empty (enable bit 1 with the pending flag set) reads 0x2 and ranks fourth. Modem status (enable bit 3 with any delta bit set) reads 0x0 and ranks last.
- R5: With no enabled cause, bits 3:0 read 0x1. The request output is 1 exactly when bit 0 of the identification byte is 0.
- R6: Bits 7:6 of the identification byte read 11 while the FIFO-enable input is 1 and 00 otherwise. Bits 5:4 always read 0.
- R7: Reading the identification byte while it reports 0x2 clears the pending flag from the next cycle. A read that reports any other value leaves the flag unchanged.
- R8: An enable write that changes bit 1 re-samples the flag. The flag becomes set if the new bit 1 is 1 and the THRE input is 1, and clear otherwise. An enable write that leaves bit 1 unchanged does not touch the flag.
- R9: A transmit FIFO reset sets the flag, a transmit holding write clears it, and a drained pulse sets it. Same-cycle ranking: FIFO reset, then holding write, then drained pulse, then enable re-sample, then identification-read clear.
- R10: The enable register stores bits 3:0 of the write data and ignores bits 7:4. It reads back on `ier_q` and resets to 0.
- R11: During and after reset, the identification byte reads 0x01 (FIFOs disabled), the request output is 0, and the flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| iir_rd | input | 1 | Identification byte read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| tx_fifo_rst | input | 1 | Transmit FIFO reset strobe |
| tx_drained | input | 1 | Pulse from transmit path: holding stage emptied |
| thre | input | 1 | Current transmit-holding-empty line status bit |
| lsr_err | input | 4 | Break, framing, parity, overrun error bits |
| data_ready | input | 1 | Receive data-ready flag |
| rx_timeout | input | 1 | Receive character timeout pending |
| rx_count | input | CW | Receive FIFO fill count |
| rx_trig | input | CW | Receive FIFO trigger level |
| fifo_en | input | 1 | FIFO enable bit |
| msr_delta | input | 4 | Modem status delta bits |
| ier_q | output | 4 | Enable register contents |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
An identification read that acknowledges a transmit-empty cause can land in the same cycle as a drained pulse, an enable write, a holding write or a FIFO reset. The bench drives these strobes together on one clock edge after the flag has been made pending. It then judges the result one cycle later from the identification byte, with only enable bit 1 set so that 0x2 against 0x1 shows the flag. A separate stimulus table checks the ranking by making many causes active at once and expecting only the highest enabled one.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_LINE,
        SRC_TIMEOUT,
        SRC_RXDATA,
        SRC_TXEMPTY,
        SRC_MODEM
    } irq_src_e;

    typedef enum logic {
        THRE_IDLE,
        THRE_PEND
    } thre_state_e;

    localparam int IER_W = 4;

    // Enable register bit positions: software decodes these.
    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    function automatic logic [3:0] src_code(irq_src_e s);
        logic [3:0] c;
        unique case (s)
            SRC_NONE:    c = 4'h1;
            SRC_LINE:    c = 4'h6;
            SRC_TIMEOUT: c = 4'hC;
            SRC_RXDATA:  c = 4'h4;
            SRC_TXEMPTY: c = 4'h2;
            SRC_MODEM:   c = 4'h0;
            default:     c = 4'h1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/uart_irq_enable_reg.sv
module uart_irq_enable_reg
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [7:0]       wdata,
    output logic [IER_W-1:0] q,
    output logic             tx_bit_change,
    output logic             tx_bit_new
);
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[7:IER_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            q <= wdata[IER_W-1:0];
        end
    end

    assign tx_bit_new    = wdata[EN_TX];
    assign tx_bit_change = wr && (wdata[EN_TX] != q[EN_TX]);
endmodule

// File: rtl/uart_irq_thre_fsm.sv
module uart_irq_thre_fsm
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_reset,
    input  logic hold_write,
    input  logic drained,
    input  logic resample,
    input  logic resample_en_bit,
    input  logic thre,
    input  logic id_read,
    input  logic id_is_tx,
    output logic pend
);
    thre_state_e state_q, state_d;

    // Transition selection, ranked: FIFO_RESET, TX_WRITE, TX_DRAINED,
    // ENABLE_RESAMPLE, ID_READ_ACK.
    always_comb begin
        state_d = state_q;
        if (fifo_reset) begin
            state_d = THRE_PEND;
        end else if (hold_write) begin
            state_d = THRE_IDLE;
        end else if (drained) begin
            state_d = THRE_PEND;
        end else if (resample) begin
            state_d = (resample_en_bit && thre) ? THRE_PEND : THRE_IDLE;
        end else begin
            unique case (state_q)
                THRE_IDLE: state_d = THRE_IDLE;
                THRE_PEND: state_d = (id_read && id_is_tx) ? THRE_IDLE : THRE_PEND;
                default:   state_d = THRE_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= THRE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            THRE_IDLE: pend = 1'b0;
            THRE_PEND: pend = 1'b1;
            default:   pend = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic [IER_W-1:0] ier,
    input  logic [3:0]       lsr_err,
    input  logic             data_ready,
    input  logic             rx_timeout,
    input  logic [CW-1:0]    rx_count,
    input  logic [CW-1:0]    rx_trig,
    input  logic             fifo_en,
    input  logic             tx_pend,
    input  logic [3:0]       msr_delta,
    output irq_src_e         src,
    output logic [7:0]       iir
);
    logic req_line, req_tmo, req_rx, req_tx, req_modem, rx_level_ok;

    assign rx_level_ok = !fifo_en || (rx_count >= rx_trig);
    assign req_line    = ier[EN_LINE]  && (|lsr_err);
    assign req_tmo     = ier[EN_RX]    && rx_timeout;
    assign req_rx      = ier[EN_RX]    && data_ready && rx_level_ok;
    assign req_tx      = ier[EN_TX]    && tx_pend;
    assign req_modem   = ier[EN_MODEM] && (|msr_delta);

    always_comb begin
        if (req_line)       src = SRC_LINE;
        else if (req_tmo)   src = SRC_TIMEOUT;
        else if (req_rx)    src = SRC_RXDATA;
        else if (req_tx)    src = SRC_TXEMPTY;
        else if (req_modem) src = SRC_MODEM;
        else                src = SRC_NONE;
    end

    assign iir = {{2{fifo_en}}, 2'b00, src_code(src)};
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [7:0]       ier_wdata,
    input  logic             iir_rd,
    input  logic             thr_wr,
    input  logic             tx_fifo_rst,
    input  logic             tx_drained,
    input  logic             thre,
    input  logic [3:0]       lsr_err,
    input  logic             data_ready,
    input  logic             rx_timeout,
    input  logic [CW-1:0]    rx_count,
    input  logic [CW-1:0]    rx_trig,
    input  logic             fifo_en,
    input  logic [3:0]       msr_delta,
    output logic [IER_W-1:0] ier_q,
    output logic [7:0]       iir,
    output logic             irq
);
    logic     tx_bit_change, tx_bit_new, thre_pend;
    irq_src_e src;

    uart_irq_enable_reg u_ier (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr            (ier_wr),
        .wdata         (ier_wdata),
        .q             (ier_q),
        .tx_bit_change (tx_bit_change),
        .tx_bit_new    (tx_bit_new)
    );

    uart_irq_thre_fsm u_thre (
        .clk             (clk),
        .rst_n           (rst_n),
        .fifo_reset      (tx_fifo_rst),
        .hold_write      (thr_wr),
        .drained         (tx_drained),
        .resample        (tx_bit_change),
        .resample_en_bit (tx_bit_new),
        .thre            (thre),
        .id_read         (iir_rd),
        .id_is_tx        (src == SRC_TXEMPTY),
        .pend            (thre_pend)
    );

    uart_irq_prio #(.CW(CW)) u_prio (
        .ier        (ier_q),
        .lsr_err    (lsr_err),
        .data_ready (data_ready),
        .rx_timeout (rx_timeout),
        .rx_count   (rx_count),
        .rx_trig    (rx_trig),
        .fifo_en    (fifo_en),
        .tx_pend    (thre_pend),
        .msr_delta  (msr_delta),
        .src        (src),
        .iir        (iir)
    );

    assign irq = (src != SRC_NONE);
endmodule

// File: rtl/uart_irq_arbiter_chk.sv
module uart_irq_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ier_wr,
    input logic       iir_rd,
    input logic       thr_wr,
    input logic       tx_fifo_rst,
    input logic       tx_drained,
    input logic [3:0] lsr_err,
    input logic       rx_timeout,
    input logic       fifo_en,
    input logic [3:0] ier_q,
    input logic [7:0] iir,
    input logic       irq,
    input logic       thre_pend
);
    assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !iir[0]);

    assert_fifo_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (iir[7:6] == {2{fifo_en}}) && (iir[5:4] == 2'b00));

    assert_line_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q[2] && (|lsr_err)) |-> (iir[3:0] == 4'h6));

    assert_timeout_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q[0] && rx_timeout && !(ier_q[2] && (|lsr_err))) |-> (iir[3:0] == 4'hC));

    assert_fifo_rst_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fifo_rst |=> thre_pend);

    assert_hold_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !tx_fifo_rst) |=> !thre_pend);

    assert_read_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && (iir[3:0] == 4'h2) && !tx_fifo_rst && !tx_drained && !ier_wr)
        |=> !thre_pend);
endmodule

bind uart_irq_arbiter uart_irq_arbiter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ier_wr      (ier_wr),
    .iir_rd      (iir_rd),
    .thr_wr      (thr_wr),
    .tx_fifo_rst (tx_fifo_rst),
    .tx_drained  (tx_drained),
    .lsr_err     (lsr_err),
    .rx_timeout  (rx_timeout),
    .fifo_en     (fifo_en),
    .ier_q       (ier_q),
    .iir         (iir),
    .irq         (irq),
    .thre_pend   (thre_pend)
);

// File: tb/uart_irq_arbiter_test.sv
module uart_irq_arbiter_test;
    localparam int CW = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          ier_wr = 1'b0, iir_rd = 1'b0, thr_wr = 1'b0;
    logic          tx_fifo_rst = 1'b0, tx_drained = 1'b0, thre = 1'b0;
    logic [7:0]    ier_wdata = '0;
    logic [3:0]    lsr_err = '0, msr_delta = '0;
    logic          data_ready = 1'b0, rx_timeout = 1'b0, fifo_en = 1'b0;
    logic [CW-1:0] rx_count = '0, rx_trig = '0;
    logic [3:0]    ier_q;
    logic [7:0]    iir;
    logic          irq;

    uart_irq_arbiter uut (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .iir_rd(iir_rd), .thr_wr(thr_wr), .tx_fifo_rst(tx_fifo_rst),
        .tx_drained(tx_drained), .thre(thre), .lsr_err(lsr_err),
        .data_ready(data_ready), .rx_timeout(rx_timeout), .rx_count(rx_count),
        .rx_trig(rx_trig), .fifo_en(fifo_en), .msr_delta(msr_delta),
        .ier_q(ier_q), .iir(iir), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write enable register; returns at the falling edge after it took effect.
    task automatic write_ier(logic [7:0] v);
        @(negedge clk);
        ier_wr = 1'b1;
        ier_wdata = v;
        @(negedge clk);
        ier_wr = 1'b0;
        #1;
    endtask

    task automatic clear_inputs();
        lsr_err = '0; msr_delta = '0; data_ready = 1'b0; rx_timeout = 1'b0;
        fifo_en = 1'b0; rx_count = '0; rx_trig = '0;
    endtask

    // {ier, err, dr, tmo, count, trig, fifo_en, delta, expected iir}
    localparam int NV = 12;
    localparam logic [32:0] VEC [NV] = '{
        {4'h0, 4'h0, 1'b0, 1'b0, 5'd0,  5'd0,  1'b0, 4'h0, 8'h01}, // R5 idle
        {4'hF, 4'h1, 1'b1, 1'b1, 5'd0,  5'd0,  1'b0, 4'h1, 8'h06}, // R1 over all
        {4'hB, 4'hF, 1'b0, 1'b1, 5'd0,  5'd0,  1'b1, 4'h0, 8'hCC}, // R2 line masked
        {4'h1, 4'h0, 1'b1, 1'b0, 5'd0,  5'd0,  1'b0, 4'h0, 8'h04}, // R3 no fifo
        {4'h1, 4'h0, 1'b1, 1'b0, 5'd3,  5'd4,  1'b1, 4'h0, 8'hC1}, // R3 below trig
        {4'h1, 4'h0, 1'b1, 1'b0, 5'd4,  5'd4,  1'b1, 4'h0, 8'hC4}, // R3 at trig
        {4'h8, 4'h0, 1'b0, 1'b0, 5'd0,  5'd0,  1'b0, 4'h2, 8'h00}, // R4 modem
        {4'h7, 4'h0, 1'b0, 1'b0, 5'd0,  5'd0,  1'b0, 4'hF, 8'h01}, // R4 modem masked
        {4'h4, 4'h8, 1'b0, 1'b0, 5'd0,  5'd0,  1'b0, 4'h0, 8'h06}, // R1 break only
        {4'h0, 4'hF, 1'b1, 1'b1, 5'd9,  5'd1,  1'b1, 4'hF, 8'hC1}, // R5 all masked, R6
        {4'h9, 4'h0, 1'b1, 1'b0, 5'd0,  5'd8,  1'b1, 4'h4, 8'hC0}, // R3/R4 falls to modem
        {4'h1, 4'h0, 1'b1, 1'b1, 5'd14, 5'd14, 1'b1, 4'h0, 8'hCC}  // R2 over rx data
    };

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R11 iir in reset", iir, 8'h01);
        check("R11 irq in reset", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R11 iir after reset", iir, 8'h01);
        check("R10 ier after reset", {4'b0, ier_q}, 8'h00);

        // Ranking table, flag stays clear because thre is 0.
        for (int i = 0; i < NV; i++) begin
            write_ier({4'h0, VEC[i][32:29]});
            lsr_err    = VEC[i][28:25];
            data_ready = VEC[i][24];
            rx_timeout = VEC[i][23];
            rx_count   = VEC[i][22:18];
            rx_trig    = VEC[i][17:13];
            fifo_en    = VEC[i][12];
            msr_delta  = VEC[i][11:8];
            #1;
            check($sformatf("table %0d iir (R1 R2 R3 R4 R6)", i), iir, VEC[i][7:0]);
            check($sformatf("table %0d irq (R5)", i), {7'b0, irq}, {7'b0, ~VEC[i][0]});
        end
        clear_inputs();

        // R10: upper write bits ignored
        write_ier(8'hF5);
        check("R10 ier keeps low bits", {4'b0, ier_q}, 8'h05);
        write_ier(8'h00);

        // R8: enabling bit 1 with thre=1 sets the flag
        thre = 1'b1;
        write_ier(8'h02);
        check("R8 resample sets", iir, 8'h02);
        check("R5 irq with tx empty", {7'b0, irq}, 8'h01);

        // R7: read acknowledging 0x2 clears
        @(negedge clk); iir_rd = 1'b1;
        @(negedge clk); iir_rd = 1'b0; #1;
        check("R7 read clears", iir, 8'h01);

        // R9: drained pulse sets, holding write clears, FIFO reset sets
        @(negedge clk); tx_drained = 1'b1;
        @(negedge clk); tx_drained = 1'b0; #1;
        check("R9 drained sets", iir, 8'h02);
        @(negedge clk); thr_wr = 1'b1;
        @(negedge clk); thr_wr = 1'b0; #1;
        check("R9 holding write clears", iir, 8'h01);
        @(negedge clk); tx_fifo_rst = 1'b1;
        @(negedge clk); tx_fifo_rst = 1'b0; #1;
        check("R9 fifo reset sets", iir, 8'h02);

        // R8: write leaving bit 1 unchanged keeps flag; R7: read of 0x4 keeps flag
        write_ier(8'h03);
        data_ready = 1'b1; #1;
        check("R3 rx data over tx", iir, 8'h04);
        @(negedge clk); iir_rd = 1'b1;
        @(negedge clk); iir_rd = 1'b0;
        data_ready = 1'b0; #1;
        check("R7 R8 flag kept", iir, 8'h02);

        // R4: tx empty outranks modem
        write_ier(8'h0A);
        msr_delta = 4'h1; #1;
        check("R4 tx over modem", iir, 8'h02);
        msr_delta = 4'h0;

        // R8: clearing bit 1 clears; setting it again with thre=0 stays clear
        write_ier(8'h00);
        thre = 1'b0;
        write_ier(8'h02);
        check("R8 resample with thre low", iir, 8'h01);

        // R9 collisions: read ack vs drained pulse
        @(negedge clk); tx_fifo_rst = 1'b1;
        @(negedge clk); tx_fifo_rst = 1'b0; #1;
        check("R9 setup pend", iir, 8'h02);
        @(negedge clk); iir_rd = 1'b1; tx_drained = 1'b1;
        @(negedge clk); iir_rd = 1'b0; tx_drained = 1'b0; #1;
        check("R9 drained beats read ack", iir, 8'h02);
        @(negedge clk); thr_wr = 1'b1; tx_fifo_rst = 1'b1;
        @(negedge clk); thr_wr = 1'b0; tx_fifo_rst = 1'b0; #1;
        check("R9 fifo reset beats holding write", iir, 8'h02);
        @(negedge clk); thr_wr = 1'b1; tx_drained = 1'b1;
        @(negedge clk); thr_wr = 1'b0; tx_drained = 1'b0; #1;
        check("R9 holding write beats drained", iir, 8'h01);
        // enable re-sample (bit 1 -> 0) vs drained pulse: drained wins
        @(negedge clk); ier_wr = 1'b1; ier_wdata = 8'h00; tx_drained = 1'b1;
        @(negedge clk); ier_wr = 1'b0; tx_drained = 1'b0;
        write_ier(8'h00); // bit 1 already 0: no re-sample
        thre = 1'b0;
        @(negedge clk); ier_wr = 1'b1; ier_wdata = 8'h02; // 0->1 with thre low clears
        @(negedge clk); ier_wr = 1'b0; #1;
        check("R9 R8 resample after drained", iir, 8'h01);

        // R11: reset in the middle clears everything
        @(negedge clk); tx_fifo_rst = 1'b1;
        @(negedge clk); tx_fifo_rst = 1'b0;
        rst_n = 1'b0;
        @(negedge clk); #1;
        check("R11 iir after mid reset", iir, 8'h01);
        check("R10 ier after mid reset", {4'b0, ier_q}, 8'h00);
        rst_n = 1'b1;
        write_ier(8'h02);
        check("R11 flag cleared by reset", iir, 8'h01);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule